// File: doc/BRIEF.md
# Dual-Channel DAC Code Controller with Two-Wire Slave Port

This block is the digital front of a two-channel 10-bit converter. A two-wire serial slave recovers start and stop events and the bits of each byte. It matches a 7-bit bus address and acknowledges on the ninth clock. It then decodes short command frames that set the code of channel A, channel B or both channels together. Each channel keeps a working code, which drives its output, and a retained code, which is copied into the working code when the block leaves reset.

Commands can write a full 10-bit code, load one of three fixed codes, copy the retained code into the working code, or power a channel down. Writes to retained storage, which covers the retained codes and the device-type field of the address, are held until the frame closes with a stop. A read frame returns a status byte. The bus lines are sampled through synchronisers on the system clock. The slave only ever pulls SDA low.

Top module: `dacctl_top`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both seen on the synchronised lines. A start received in the middle of a frame abandons that frame, including any retained-storage write it was holding.
- R2: The first byte after a start is the address. Bits 7:4 must equal the device-type field, bits 3:1 must equal `pin_addr_i`, and bit 0 selects read (1) or write (0). The slave pulls SDA low during the ninth SCL clock only when the address matches. With no match it ignores the rest of the frame.
- R3: After reset, the device-type field is `ID_INIT` (default 4'b0101) and the retained codes are `NV_INIT_A` and `NV_INIT_B`. One cycle later each working code equals its retained code, and both power-down flags are 0.
- R4: Command byte bits 7:4 form the opcode and bits 1:0 select the target (01 = A, 10 = B, 11 = both). Opcode 0 is a three-byte frame. Its 10-bit value takes bits 9:8 from command bits 3:2 and bits 7:0 from the data byte, and it is loaded into the working code of each target when the data byte arrives.
- R5: Opcode 1 carries a value in the same way as opcode 0, but loads it into the retained code of each target. This happens only when the frame ends with a stop. The working code does not change.
- R6: Opcode 2 loads 10'h000, opcode 3 loads 10'h3FF and opcode 4 loads 10'h200 into the working code of each target. These are two-byte frames.
- R7: Opcode 5 copies the retained code of each target into its working code.
- R8: Opcode 6 sets the power-down flag of each target. Any later load of that channel's working code (by opcode 0, 2, 3, 4 or 5) clears the flag.
- R9: Opcode 7 is a three-byte frame. Bits 3:0 of its data byte become the new device-type field when the frame ends with a stop. After that, the slave answers the new address and no longer answers the old one.
- R10: Opcodes 8 to 15, target bits 00 on opcodes 0 to 6, and a three-byte command cut short by a stop change no register.
- R11: In a read frame the slave sends the byte {device-type field, 2'b00, power-down B, power-down A}, MSB first. It changes SDA only while SCL is low. It repeats the byte while the master acknowledges, and releases the bus after a not-acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| pin_addr_i | input | 3 | Levels of the three address straps |
| sda_pull_o | output | 1 | Drive SDA low when 1 (open-drain enable) |
| code_a_o | output | 10 | Working code of channel A |
| code_b_o | output | 10 | Working code of channel B |
| pd_a_o | output | 1 | Channel A powered down |
| pd_b_o | output | 1 | Channel B powered down |

## Verification
A table of frames sends each opcode to channel A alone, channel B alone and both channels. The target values are chosen so that the high bits taken from the command byte and the low bits taken from the data byte can be told apart. Each channel's value differs from the other channel's and from the fixed codes, so a wrong target or a mixed-up channel shows up. Directed frames cover a foreign address, a command cut short by a stop, and a retained write abandoned by a repeated start. Further frames read status with power-down set, move the device-type field, and reset after retained storage has been changed. Together these separate "applied at once" from "applied on stop" and separate the working codes from the retained codes.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

    localparam int DAC_W  = 10;
    localparam int NCH    = 2;
    localparam int ID_W   = 4;
    localparam int PIN_W  = 3;
    localparam int HI_W   = DAC_W - 8;

    typedef enum logic [3:0] {
        OP_WR_VOL = 4'd0,
        OP_WR_NV  = 4'd1,
        OP_ZERO   = 4'd2,
        OP_FULL   = 4'd3,
        OP_MID    = 4'd4,
        OP_RECALL = 4'd5,
        OP_PDOWN  = 4'd6,
        OP_CFG    = 4'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ACT_LOAD,
        ACT_RECALL,
        ACT_PDOWN,
        ACT_NVWR,
        ACT_CFG
    } act_e;

    typedef struct packed {
        logic             vld;
        act_e             kind;
        logic [NCH-1:0]   tgt;
        logic [DAC_W-1:0] val;
    } act_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_WRITE,
        BUS_READ
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_DATA,
        PH_DONE
    } phase_e;

    function automatic logic [DAC_W-1:0] preset_code(input opcode_e op);
        case (op)
            OP_FULL: preset_code = '1;
            OP_MID:  preset_code = DAC_W'(1) << (DAC_W - 1);
            default: preset_code = '0;
        endcase
    endfunction

endpackage

// File: rtl/dacctl_bus.sv
module dacctl_bus
    import dacctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [PIN_W-1:0] pin_addr_i,
    input  logic [ID_W-1:0]  dev_id_i,
    input  logic [7:0]       tx_byte_i,
    output logic             sda_pull_o,
    output logic             start_o,
    output logic             stop_o,
    output logic             byte_vld_o,
    output logic [7:0]       byte_o
);

    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_s, sda_s, scl_p, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] in_byte;
    logic addr_hit;

    bus_st_e    st_q;
    logic [3:0] cnt_q;
    logic [7:0] sh_q, tx_q;
    logic       oe_q, hit_q, rw_q, mack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_p    <= scl_s;
            sda_p    <= sda_s;
        end
    end

    always_comb begin
        scl_s     = scl_sync[SYNC_STAGES-1];
        sda_s     = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
        in_byte   = {sh_q[6:0], sda_s};
        addr_hit  = (in_byte[7:4] == dev_id_i) && (in_byte[3:1] == pin_addr_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= BUS_IDLE;
            cnt_q      <= '0;
            sh_q       <= '0;
            tx_q       <= '0;
            oe_q       <= 1'b0;
            hit_q      <= 1'b0;
            rw_q       <= 1'b0;
            mack_q     <= 1'b0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            byte_vld_o <= 1'b0;
            if (start_det) begin
                st_q  <= BUS_ADDR;
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else if (stop_det) begin
                st_q  <= BUS_IDLE;
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else if (scl_rise) begin
                case (st_q)
                    BUS_ADDR, BUS_WRITE: begin
                        if (cnt_q < 4'd8) begin
                            sh_q  <= in_byte;
                            cnt_q <= cnt_q + 4'd1;
                            if (cnt_q == 4'd7) begin
                                if (st_q == BUS_ADDR) begin
                                    hit_q <= addr_hit;
                                    rw_q  <= in_byte[0];
                                end else begin
                                    byte_vld_o <= 1'b1;
                                    byte_o     <= in_byte;
                                end
                            end
                        end else if (cnt_q == 4'd8) begin
                            cnt_q <= 4'd9;
                        end
                    end
                    BUS_READ: begin
                        if (cnt_q == 4'd8) mack_q <= ~sda_s;
                        if (cnt_q != 4'd9) cnt_q <= cnt_q + 4'd1;
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (st_q)
                    BUS_ADDR: begin
                        if (cnt_q == 4'd8) begin
                            if (hit_q) oe_q <= 1'b1;
                            else       st_q <= BUS_IDLE;
                        end else if (cnt_q == 4'd9) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                st_q <= BUS_READ;
                                tx_q <= tx_byte_i;
                                oe_q <= ~tx_byte_i[7];
                            end else begin
                                st_q <= BUS_WRITE;
                                oe_q <= 1'b0;
                            end
                        end
                    end
                    BUS_WRITE: begin
                        if (cnt_q == 4'd8) oe_q <= 1'b1;
                        else if (cnt_q == 4'd9) begin
                            oe_q  <= 1'b0;
                            cnt_q <= '0;
                        end
                    end
                    BUS_READ: begin
                        if (cnt_q < 4'd8) oe_q <= ~tx_q[3'd7 - cnt_q[2:0]];
                        else if (cnt_q == 4'd8) oe_q <= 1'b0;
                        else if (mack_q) begin
                            cnt_q <= '0;
                            tx_q  <= tx_byte_i;
                            oe_q  <= ~tx_byte_i[7];
                        end else begin
                            st_q <= BUS_IDLE;
                            oe_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = oe_q;
    assign start_o    = start_det;
    assign stop_o     = stop_det;

    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> (!$past(scl_s) || $past(start_det || stop_det))); // R11

    AST_BYTE_ONLY_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> $past(scl_rise)); // R2

endmodule

// File: rtl/dacctl_cmd.sv
module dacctl_cmd
    import dacctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    output act_t       act_o
);

    phase_e           phase_q;
    logic [7:0]       cmd_q;
    act_t             pend_q, act_q;
    opcode_e          op_now, op_held;
    logic [DAC_W-1:0] data_val;

    always_comb begin
        op_now   = opcode_e'(byte_i[7:4]);
        op_held  = opcode_e'(cmd_q[7:4]);
        data_val = {cmd_q[3:2], byte_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_DONE;
            cmd_q   <= '0;
            pend_q  <= '0;
            act_q   <= '0;
        end else begin
            act_q <= '0;
            if (start_i) begin
                phase_q <= PH_CMD;
                pend_q  <= '0;
            end else if (stop_i) begin
                if (pend_q.vld) act_q <= pend_q;
                pend_q  <= '0;
                phase_q <= PH_DONE;
            end else if (byte_vld_i) begin
                case (phase_q)
                    PH_CMD: begin
                        cmd_q   <= byte_i;
                        phase_q <= PH_DONE;
                        if (op_now == OP_CFG) begin
                            phase_q <= PH_DATA;
                        end else if (byte_i[1:0] != 2'b00) begin
                            case (op_now)
                                OP_WR_VOL, OP_WR_NV: phase_q <= PH_DATA;
                                OP_ZERO, OP_FULL, OP_MID:
                                    act_q <= '{vld: 1'b1, kind: ACT_LOAD,
                                               tgt: byte_i[1:0], val: preset_code(op_now)};
                                OP_RECALL:
                                    act_q <= '{vld: 1'b1, kind: ACT_RECALL,
                                               tgt: byte_i[1:0], val: '0};
                                OP_PDOWN:
                                    act_q <= '{vld: 1'b1, kind: ACT_PDOWN,
                                               tgt: byte_i[1:0], val: '0};
                                default: ;
                            endcase
                        end
                    end
                    PH_DATA: begin
                        phase_q <= PH_DONE;
                        case (op_held)
                            OP_WR_VOL:
                                act_q <= '{vld: 1'b1, kind: ACT_LOAD,
                                           tgt: cmd_q[1:0], val: data_val};
                            OP_WR_NV:
                                pend_q <= '{vld: 1'b1, kind: ACT_NVWR,
                                            tgt: cmd_q[1:0], val: data_val};
                            OP_CFG:
                                pend_q <= '{vld: 1'b1, kind: ACT_CFG,
                                            tgt: '1, val: {{(DAC_W-ID_W){1'b0}}, byte_i[ID_W-1:0]}};
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    assign act_o = act_q;

    AST_RETAINED_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        (act_q.vld && (act_q.kind == ACT_NVWR || act_q.kind == ACT_CFG)) |-> $past(stop_i)); // R5

    AST_NO_EMPTY_TARGET: assert property (@(posedge clk) disable iff (rst)
        act_q.vld |-> (act_q.tgt != '0)); // R10

    AST_LOAD_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (rst)
        (act_q.vld && (act_q.kind == ACT_LOAD || act_q.kind == ACT_RECALL ||
                       act_q.kind == ACT_PDOWN)) |-> $past(byte_vld_i)); // R4

endmodule

// File: rtl/dacctl_regs.sv
module dacctl_regs
    import dacctl_pkg::*;
#(
    parameter logic [DAC_W-1:0] NV_INIT_A = 10'h155,
    parameter logic [DAC_W-1:0] NV_INIT_B = 10'h2AA,
    parameter logic [ID_W-1:0]  ID_INIT   = 4'b0101
) (
    input  logic                      clk,
    input  logic                      rst,
    input  act_t                      act_i,
    output logic [NCH-1:0][DAC_W-1:0] code_o,
    output logic [NCH-1:0]            pd_o,
    output logic [ID_W-1:0]           dev_id_o
);

    localparam logic [NCH-1:0][DAC_W-1:0] NV_INIT = {NV_INIT_B, NV_INIT_A};

    logic                      boot_q;
    logic [NCH-1:0][DAC_W-1:0] vol_q, nv_q;
    logic [NCH-1:0]            pd_q;
    logic [ID_W-1:0]           id_q;

    always_ff @(posedge clk) begin
        if (rst) boot_q <= 1'b1;
        else     boot_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) id_q <= ID_INIT;
        else if (act_i.vld && act_i.kind == ACT_CFG) id_q <= act_i.val[ID_W-1:0];
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                nv_q[ch]  <= NV_INIT[ch];
                vol_q[ch] <= '0;
                pd_q[ch]  <= 1'b0;
            end else if (boot_q) begin
                vol_q[ch] <= nv_q[ch];
            end else if (act_i.vld && act_i.tgt[ch]) begin
                case (act_i.kind)
                    ACT_LOAD: begin
                        vol_q[ch] <= act_i.val;
                        pd_q[ch]  <= 1'b0;
                    end
                    ACT_RECALL: begin
                        vol_q[ch] <= nv_q[ch];
                        pd_q[ch]  <= 1'b0;
                    end
                    ACT_PDOWN: pd_q[ch]  <= 1'b1;
                    ACT_NVWR:  nv_q[ch]  <= act_i.val;
                    default: ;
                endcase
            end
        end

        AST_PD_SET_BY_CMD: assert property (@(posedge clk) disable iff (rst)
            $rose(pd_q[ch]) |-> $past(act_i.vld && act_i.kind == ACT_PDOWN && act_i.tgt[ch])); // R8

        AST_BOOT_COPIES_RETAINED: assert property (@(posedge clk) disable iff (rst)
            boot_q |=> (vol_q[ch] == nv_q[ch])); // R3
    end

    assign code_o   = vol_q;
    assign pd_o     = pd_q;
    assign dev_id_o = id_q;

endmodule

// File: rtl/dacctl_top.sv
module dacctl_top
    import dacctl_pkg::*;
#(
    parameter logic [DAC_W-1:0] NV_INIT_A   = 10'h155,
    parameter logic [DAC_W-1:0] NV_INIT_B   = 10'h2AA,
    parameter logic [ID_W-1:0]  ID_INIT     = 4'b0101,
    parameter int               SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [PIN_W-1:0] pin_addr_i,
    output logic             sda_pull_o,
    output logic [DAC_W-1:0] code_a_o,
    output logic [DAC_W-1:0] code_b_o,
    output logic             pd_a_o,
    output logic             pd_b_o
);

    logic                      start_w, stop_w, byte_vld_w;
    logic [7:0]                byte_w, tx_w;
    logic [ID_W-1:0]           dev_id_w;
    act_t                      act_w;
    logic [NCH-1:0][DAC_W-1:0] code_w;
    logic [NCH-1:0]            pd_w;

    assign tx_w = {dev_id_w, 2'b00, pd_w[1], pd_w[0]};

    dacctl_bus #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .pin_addr_i (pin_addr_i),
        .dev_id_i   (dev_id_w),
        .tx_byte_i  (tx_w),
        .sda_pull_o (sda_pull_o),
        .start_o    (start_w),
        .stop_o     (stop_w),
        .byte_vld_o (byte_vld_w),
        .byte_o     (byte_w)
    );

    dacctl_cmd u_cmd (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_w),
        .stop_i     (stop_w),
        .byte_vld_i (byte_vld_w),
        .byte_i     (byte_w),
        .act_o      (act_w)
    );

    dacctl_regs #(
        .NV_INIT_A (NV_INIT_A),
        .NV_INIT_B (NV_INIT_B),
        .ID_INIT   (ID_INIT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .act_i    (act_w),
        .code_o   (code_w),
        .pd_o     (pd_w),
        .dev_id_o (dev_id_w)
    );

    assign code_a_o = code_w[0];
    assign code_b_o = code_w[1];
    assign pd_a_o   = pd_w[0];
    assign pd_b_o   = pd_w[1];

endmodule

// File: tb/sim_dacctl_top.sv
module sim_dacctl_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       pull;
    logic [9:0] code_a, code_b;
    logic       pd_a, pd_b;
    logic       sda_line;

    int n_chk = 0;
    int n_bad = 0;

    assign sda_line = sda_m & ~pull;

    always #2 clk = ~clk;

    dacctl_top u0 (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .pin_addr_i (pins),
        .sda_pull_o (pull),
        .code_a_o   (code_a),
        .code_b_o   (code_b),
        .pd_a_o     (pd_a),
        .pd_b_o     (pd_b)
    );

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] dat;
        logic       three;
        logic [9:0] a;
        logic [9:0] b;
        logic       pa;
        logic       pb;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{8'h0D, 8'hC7, 1'b1, 10'h3C7, 10'h2AA, 1'b0, 1'b0}, // R4 A only
        '{8'h02, 8'h12, 1'b1, 10'h3C7, 10'h012, 1'b0, 1'b0}, // R4 B only
        '{8'h0B, 8'h5A, 1'b1, 10'h25A, 10'h25A, 1'b0, 1'b0}, // R4 both
        '{8'h21, 8'h00, 1'b0, 10'h000, 10'h25A, 1'b0, 1'b0}, // R6 zero A
        '{8'h32, 8'h00, 1'b0, 10'h000, 10'h3FF, 1'b0, 1'b0}, // R6 full B
        '{8'h43, 8'h00, 1'b0, 10'h200, 10'h200, 1'b0, 1'b0}, // R6 mid both
        '{8'h61, 8'h00, 1'b0, 10'h200, 10'h200, 1'b1, 1'b0}, // R8 power-down A
        '{8'h52, 8'h00, 1'b0, 10'h200, 10'h2AA, 1'b1, 1'b0}, // R7 recall B
        '{8'h31, 8'h00, 1'b0, 10'h3FF, 10'h2AA, 1'b0, 1'b0}, // R8 load clears flag
        '{8'h93, 8'h00, 1'b0, 10'h3FF, 10'h2AA, 1'b0, 1'b0}, // R10 unknown opcode
        '{8'h20, 8'h00, 1'b0, 10'h3FF, 10'h2AA, 1'b0, 1'b0}, // R10 empty target
        '{8'h63, 8'h00, 1'b0, 10'h3FF, 10'h2AA, 1'b1, 1'b1}, // R8 power-down both
        '{8'h53, 8'h00, 1'b0, 10'h155, 10'h2AA, 1'b0, 1'b0}  // R7 recall both
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(2);
        scl   = 1'b1; tick(4);
        sda_m = 1'b0; tick(4);
        scl   = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(4);
        scl   = 1'b1; tick(4);
        sda_m = 1'b1; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(4);
            scl = 1'b1; tick(4);
            scl = 1'b0; tick(2);
        end
        sda_m = 1'b1; tick(4);
        scl = 1'b1; tick(2);
        ack = ~sda_line;
        tick(2);
        scl = 1'b0; tick(4);
    endtask

    task automatic read_byte(output logic [7:0] b, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            tick(4);
            scl = 1'b1; tick(2);
            b[i] = sda_line;
            tick(2);
            scl = 1'b0;
        end
        tick(2);
        sda_m = give_ack ? 1'b0 : 1'b1; tick(2);
        scl = 1'b1; tick(4);
        scl = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic frame(input logic [7:0] addr, input logic [7:0] c,
                         input logic [7:0] d, input logic three, output logic ack);
        logic dummy;
        bus_start();
        send_byte(addr, ack);
        send_byte(c, dummy);
        if (three) send_byte(d, dummy);
        bus_stop();
        tick(6);
    endtask

    task automatic do_reset();
        rst = 1'b1; scl = 1'b1; sda_m = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(4);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic       ack;
        logic [7:0] rb, rb2;

        do_reset();
        // R3: reset state and boot copy of retained codes
        chk(code_a == 10'h155, "R3 code A after reset", code_a, 10'h155);
        chk(code_b == 10'h2AA, "R3 code B after reset", code_b, 10'h2AA);
        chk({pd_b, pd_a} == 2'b00, "R3 power-down flags after reset", {pd_b, pd_a}, 0);
        chk(pull == 1'b0, "R3 bus released after reset", pull, 0);

        // R11 / R3: status read shows default device type
        bus_start();
        send_byte(8'h5B, ack);
        chk(ack == 1'b1, "R2 ack on read address", ack, 1);
        read_byte(rb, 1'b0);
        bus_stop();
        tick(6);
        chk(rb == 8'h50, "R11 status byte after reset", rb, 8'h50);

        // R2: foreign address (pins 110) gets no ack and no change
        frame(8'h5C, 8'h23, 8'h00, 1'b0, ack);
        chk(ack == 1'b0, "R2 no ack for foreign address", ack, 0);
        chk(code_a == 10'h155 && code_b == 10'h2AA, "R2 foreign frame ignored",
            {code_b, code_a}, {10'h2AA, 10'h155});

        // R4 R6 R7 R8 R10: command table
        for (int v = 0; v < NV; v++) begin
            frame(8'h5A, VEC[v].cmd, VEC[v].dat, VEC[v].three, ack);
            chk(ack == 1'b1, "R2 ack on table frame", ack, 1);
            chk(code_a == VEC[v].a && code_b == VEC[v].b &&
                pd_a == VEC[v].pa && pd_b == VEC[v].pb,
                $sformatf("table row %0d (R4/R6/R7/R8/R10)", v),
                {pd_b, pd_a, code_b, code_a},
                {VEC[v].pb, VEC[v].pa, VEC[v].b, VEC[v].a});
        end

        // R11 R8: status read with both flags set, repeated on master ack
        frame(8'h5A, 8'h63, 8'h00, 1'b0, ack);
        bus_start();
        send_byte(8'h5B, ack);
        read_byte(rb, 1'b1);
        read_byte(rb2, 1'b0);
        bus_stop();
        tick(6);
        chk(rb == 8'h53, "R11 status with power-down", rb, 8'h53);
        chk(rb2 == 8'h53, "R11 repeated status byte", rb2, 8'h53);
        chk(pull == 1'b0, "R11 bus released after nack", pull, 0);
        frame(8'h5A, 8'h53, 8'h00, 1'b0, ack);

        // R5: retained write leaves working code, recall exposes it
        frame(8'h5A, 8'h11, 8'hF0, 1'b1, ack);
        chk(code_a == 10'h155, "R5 working code unchanged by retained write", code_a, 10'h155);
        frame(8'h5A, 8'h51, 8'h00, 1'b0, ack);
        chk(code_a == 10'h0F0, "R5 R7 recall of retained value", code_a, 10'h0F0);

        // R1 R5: repeated start abandons a pending retained write
        bus_start();
        send_byte(8'h5A, ack);
        send_byte(8'h12, ack);
        send_byte(8'h77, ack);
        bus_start();
        send_byte(8'h5A, ack);
        send_byte(8'h22, ack);
        bus_stop();
        tick(6);
        chk(code_b == 10'h000, "R1 frame after repeated start applied", code_b, 0);
        frame(8'h5A, 8'h52, 8'h00, 1'b0, ack);
        chk(code_b == 10'h2AA, "R1 R5 abandoned retained write", code_b, 10'h2AA);

        // R10: three-byte command cut short by a stop
        frame(8'h5A, 8'h0D, 8'h00, 1'b0, ack);
        chk(code_a == 10'h0F0, "R10 short frame ignored", code_a, 10'h0F0);

        // R9: new device type field
        frame(8'h5A, 8'h70, 8'h03, 1'b1, ack);
        frame(8'h5A, 8'h21, 8'h00, 1'b0, ack);
        chk(ack == 1'b0, "R9 old address no longer acked", ack, 0);
        chk(code_a == 10'h0F0, "R9 old address frame ignored", code_a, 10'h0F0);
        frame(8'h3A, 8'h21, 8'h00, 1'b0, ack);
        chk(ack == 1'b1, "R9 new address acked", ack, 1);
        chk(code_a == 10'h000, "R9 new address frame applied", code_a, 0);
        bus_start();
        send_byte(8'h3B, ack);
        read_byte(rb, 1'b0);
        bus_stop();
        tick(6);
        chk(rb == 8'h30, "R9 status shows new type", rb, 8'h30);

        // R3: reset restores retained defaults and device type
        do_reset();
        chk(code_a == 10'h155 && code_b == 10'h2AA, "R3 codes after second reset",
            {code_b, code_a}, {10'h2AA, 10'h155});
        frame(8'h5A, 8'h32, 8'h00, 1'b0, ack);
        chk(ack == 1'b1, "R3 default address answered after reset", ack, 1);
        chk(code_b == 10'h3FF, "R3 R6 command after reset", code_b, 10'h3FF);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule